// File: doc/BRIEF.md
# Coincident-Edge Sync Generator

This block runs next to two clock banks that are divided down from one shared fast clock. It gives advance notice of the moments when the rising edges of both banks line up. Its single output, `sync_o`, idles high. It drops low a fixed number of fast-clock cycles before each shared rising edge and goes high again on the fast cycle in which that shared edge occurs. The warning is most useful when the two banks run at a ratio that is not a whole number, such as 3:2 or 4:3, because the shared edges then recur only once every several bank periods.

The block never computes the least common multiple of the two divide ratios. It keeps one phase counter per bank, each running in step with that bank's divider. It then works out whether the period of the faster bank that has just begun is the final one before the next shared edge. Releasing reset puts both phase counters at zero, so the first cycle after release is a shared edge. The ratios are expected to stay constant while the block is out of reset.

Top module: `edge_sync_gen`

## Requirements
- R1: While `rst_ni` is low, `sync_o` is high. In the first fast cycle after release (count k = 0), `sync_o` is high, and k then counts fast clock rising edges since release.
- R2: With L the least common multiple of the two effective ratios, `sync_o` is high in every cycle where k mod L = 0. These cycles are the shared rising edges of both banks.
- R3: When the two effective ratios differ, let m be the smaller one. `sync_o` is low exactly in the cycles where k mod L lies in L-m .. L-1, and is high in all other cycles.
- R4: When the two effective ratios are equal to r, `sync_o` is low in every cycle where k mod r is not 0. This gives r-1 low cycles and then one high cycle at each edge.
- R5: When both effective ratios are 1, `sync_o` stays high in every cycle.
- R6: A ratio input of 0 behaves exactly as a ratio of 1.
- R7: Swapping the two ratio values between the bank A and bank C inputs leaves the waveform on `sync_o` unchanged.
- R8: Asserting reset in the middle of a low window brings `sync_o` high by the next sampled cycle. After release the pattern starts again from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared fast clock that feeds both bank dividers |
| rst_ni | input | 1 | Synchronous active-low reset, released together with the bank dividers |
| ratio_a_i | input | RW | Divide ratio of bank A; 0 is taken as 1 |
| ratio_c_i | input | RW | Divide ratio of bank C; 0 is taken as 1 |
| sync_o | output | 1 | Sync output: low before a shared rising edge, high at it |

## Verification
When the ratios are equal, the shared edge that ends one warning window is also the first cycle of the next window. The return to high and the next fall then fall in consecutive cycles and depend on the same phase decode. Pairs such as 4:4, 1:1 and 6:1 provoke this case, and a bank ratio of 1 moves the window start onto every cycle. The bench judges it against an independent lcm-based model, which expects exactly one high cycle per shared edge. Reset arriving inside a low window is the second overlap. The bench checks it by driving reset while `sync_o` is low and requiring high on the next sampled cycle.

// File: rtl/edge_sync_pkg.sv
package edge_sync_pkg;

   // Which bank currently plays the role of the faster (smaller ratio) clock
   typedef enum logic {
      LEAD_A = 1'b0,
      LEAD_C = 1'b1
   } lead_e;

   // Bounds on the ratio width accepted by the block
   localparam int RW_MIN = 2;
   localparam int RW_MAX = 16;

endpackage

// File: rtl/esg_phase_ctr.sv
module esg_phase_ctr #(
   parameter int RW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [RW-1:0] ratio_i,
   output logic [RW-1:0] eff_o,
   output logic [RW-1:0] phase_o,
   output logic [RW-1:0] phase_nxt_o
);

   localparam logic [RW-1:0] ONE = RW'(1);

   logic [RW-1:0] phase_q;
   logic [RW-1:0] last;

   // a zero ratio is folded onto one
   assign eff_o = (ratio_i == '0) ? ONE : ratio_i;
   assign last  = eff_o - ONE;

   assign phase_nxt_o = (phase_q >= last) ? '0 : phase_q + ONE;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) phase_q <= '0;
      else         phase_q <= phase_nxt_o;
   end

   assign phase_o = phase_q;

   // R6: with the ratio held, the phase never reaches the effective ratio
   assert_phase_bounded_R6 : assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      $stable(ratio_i) |-> (phase_o < eff_o)
   );

endmodule

// File: rtl/esg_rank.sv
module esg_rank
   import edge_sync_pkg::*;
#(
   parameter int RW = 5
) (
   input  logic [RW-1:0] eff_a_i,
   input  logic [RW-1:0] eff_c_i,
   input  logic [RW-1:0] ph_a_i,
   input  logic [RW-1:0] ph_c_i,
   input  logic [RW-1:0] phn_a_i,
   input  logic [RW-1:0] phn_c_i,
   output logic [RW-1:0] rs_o,
   output logic [RW-1:0] rb_o,
   output logic [RW-1:0] ps_o,
   output logic [RW-1:0] pb_o,
   output logic [RW-1:0] psn_o,
   output logic [RW-1:0] pbn_o
);

   lead_e lead;

   // ties go to bank A; the result is the same either way
   assign lead = (eff_a_i <= eff_c_i) ? LEAD_A : LEAD_C;

   always_comb begin
      if (lead == LEAD_A) begin
         rs_o  = eff_a_i;  rb_o  = eff_c_i;
         ps_o  = ph_a_i;   pb_o  = ph_c_i;
         psn_o = phn_a_i;  pbn_o = phn_c_i;
      end else begin
         rs_o  = eff_c_i;  rb_o  = eff_a_i;
         ps_o  = ph_c_i;   pb_o  = ph_a_i;
         psn_o = phn_c_i;  pbn_o = phn_a_i;
      end
   end

   // R7: the ranked pair is always ordered small then big
   always_comb begin
      assert_rank_order_R7 : assert (rs_o <= rb_o);
   end

endmodule

// File: rtl/esg_predict.sv
module esg_predict #(
   parameter int RW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [RW-1:0] rs_i,
   input  logic [RW-1:0] rb_i,
   input  logic [RW-1:0] ps_i,
   input  logic [RW-1:0] pb_i,
   input  logic [RW-1:0] psn_i,
   input  logic [RW-1:0] pbn_i,
   output logic          sync_o
);

   logic [RW-1:0] lat_q;     // phase of the big bank at the start of the current small period
   logic [RW-1:0] lat_nxt;
   logic [RW-1:0] gap;
   logic          coin_nxt;
   logic          warn_nxt;
   logic          sync_q;

   // the small period that starts with the big bank at phase rb-rs is the final one
   assign gap      = rb_i - rs_i;
   assign coin_nxt = (psn_i == '0) && (pbn_i == '0);
   assign lat_nxt  = (psn_i == '0) ? pbn_i : lat_q;
   assign warn_nxt = (lat_nxt == gap) && !coin_nxt;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lat_q  <= '0;
         sync_q <= 1'b1;
      end else begin
         lat_q  <= lat_nxt;
         sync_q <= !warn_nxt;
      end
   end

   assign sync_o = sync_q;

   // R2: sync is high on every cycle where both banks sit at phase zero
   assert_high_at_coin_R2 : assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      ((ps_i == '0) && (pb_i == '0)) |-> sync_q
   );

   // R3: a warning window opens only on a small-bank period boundary (or one
   // cycle after it when the ratios are equal)
   assert_fall_on_boundary_R3 : assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      ($stable(rs_i) && $stable(rb_i) && $past($stable(rs_i)) && $past($stable(rb_i))
       && $fell(sync_q)) |-> ((ps_i == '0) || (rs_i == rb_i))
   );

endmodule

// File: rtl/edge_sync_gen.sv
module edge_sync_gen
   import edge_sync_pkg::*;
#(
   parameter int RW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [RW-1:0] ratio_a_i,
   input  logic [RW-1:0] ratio_c_i,
   output logic          sync_o
);

   localparam int NBANK = 2;

   if (RW < RW_MIN || RW > RW_MAX) begin : g_bad_rw
      $error("edge_sync_gen: RW out of range");
   end

   logic [RW-1:0] ratio_v [NBANK];
   logic [RW-1:0] eff_v   [NBANK];
   logic [RW-1:0] ph_v    [NBANK];
   logic [RW-1:0] phn_v   [NBANK];

   assign ratio_v[0] = ratio_a_i;
   assign ratio_v[1] = ratio_c_i;

   for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
      esg_phase_ctr #(.RW(RW)) u_ctr (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .ratio_i    (ratio_v[gi]),
         .eff_o      (eff_v[gi]),
         .phase_o    (ph_v[gi]),
         .phase_nxt_o(phn_v[gi])
      );
   end

   logic [RW-1:0] rs, rb, ps, pb, psn, pbn;

   esg_rank #(.RW(RW)) u_rank (
      .eff_a_i(eff_v[0]),
      .eff_c_i(eff_v[1]),
      .ph_a_i (ph_v[0]),
      .ph_c_i (ph_v[1]),
      .phn_a_i(phn_v[0]),
      .phn_c_i(phn_v[1]),
      .rs_o   (rs),
      .rb_o   (rb),
      .ps_o   (ps),
      .pb_o   (pb),
      .psn_o  (psn),
      .pbn_o  (pbn)
   );

   esg_predict #(.RW(RW)) u_pred (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rs_i  (rs),
      .rb_i  (rb),
      .ps_i  (ps),
      .pb_i  (pb),
      .psn_i (psn),
      .pbn_i (pbn),
      .sync_o(sync_o)
   );

   // R1: the first sampled cycle after release is a shared edge, so sync is high
   assert_high_after_reset_R1 : assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> sync_o
   );

endmodule

// File: tb/edge_sync_gen_test.sv
module edge_sync_gen_test;

   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] ra = RW'(1);
   logic [RW-1:0] rc = RW'(1);
   logic          sync;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   edge_sync_gen #(.RW(RW)) uut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ratio_a_i(ra),
      .ratio_c_i(rc),
      .sync_o   (sync)
   );

   function automatic int gcd(int a, int b);
      while (b != 0) begin
         int t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   // expected sync from the requirements: count k since release
   function automatic logic exp_sync(int a, int c, int k);
      int a0 = (a == 0) ? 1 : a;
      int c0 = (c == 0) ? 1 : c;
      int l  = a0 * c0 / gcd(a0, c0);
      int m  = (a0 < c0) ? a0 : c0;
      int kk = k % l;
      if (kk == 0) return 1'b1;
      return (kk >= l - m) ? 1'b0 : 1'b1;
   endfunction

   task automatic check(logic act, logic exp, string tag, int k);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s k=%0d ratios=%0d:%0d actual=%b expected=%b", tag, k, ra, rc, act, exp);
      end
   endtask

   // hold reset for a few cycles with the new ratios, check R1, release at a negedge
   task automatic do_reset(int a, int c);
      @(negedge clk);
      rst_n = 1'b0;
      ra = RW'(a);
      rc = RW'(c);
      repeat (3) @(negedge clk);
      check(sync, 1'b1, "R1 high in reset", -1);
      rst_n = 1'b1;
   endtask

   task automatic run_pair(int a, int c, string tag);
      int a0 = (a == 0) ? 1 : a;
      int c0 = (c == 0) ? 1 : c;
      int cyc = 3 * (a0 * c0 / gcd(a0, c0)) + 4;
      do_reset(a, c);
      check(sync, 1'b1, "R1 first cycle", 0);
      for (int k = 0; k < cyc; k++) begin
         check(sync, exp_sync(a, c, k), tag, k);
         @(negedge clk);
      end
   endtask

   // R8: reset asserted while sync is low
   task automatic t_reset_mid();
      do_reset(3, 2);
      for (int k = 0; k < 4; k++) @(negedge clk);
      check(sync, 1'b0, "R8 in window before reset", 4);
      rst_n = 1'b0;
      @(negedge clk);
      check(sync, 1'b1, "R8 high after mid-window reset", 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 14; k++) begin
         check(sync, exp_sync(3, 2, k), "R8 realigned", k);
         @(negedge clk);
      end
   endtask

   initial begin
      run_pair(1, 1, "R5 both ratio one");
      run_pair(2, 1, "R3 2:1");
      run_pair(3, 2, "R3 3:2");
      run_pair(3, 1, "R3 3:1");
      run_pair(4, 1, "R3 4:1");
      run_pair(4, 3, "R3 4:3");
      run_pair(6, 1, "R3 6:1");
      run_pair(8, 12, "R2 8:12");
      run_pair(5, 7, "R2 5:7");
      run_pair(4, 4, "R4 equal 4");
      run_pair(3, 3, "R4 equal 3");
      run_pair(2, 3, "R7 swapped 3:2");
      run_pair(1, 6, "R7 swapped 6:1");
      run_pair(0, 3, "R6 zero as one");
      run_pair(0, 0, "R6 both zero");
      t_reset_mid();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule